// File: doc/BRIEF.md
# Expanded Data Memory Access Router

This block steers byte-wide data-memory reads and writes. Each access goes either to a 256-byte on-chip expanded RAM or out over an external bus that multiplexes address and data. A request carries several fields. One says whether the address is an 8-bit register-indirect value or a 16-bit pointer. The others are the address, a read/write flag, the write data and a mode bit. The mode bit and the address width together decide the route.

The external bus is made of several pins. A low port carries the address low byte and then the data byte. A high port carries the upper address byte on pointer accesses only. An address latch strobe and active-low read and write strobes complete the bus. Each port has an output-enable instead of a bidirectional pin. When an indirect external access runs, the high port stays undriven, so that surrounding logic can put page bits on it. An internal access completes in one clock. An external cycle runs through fixed phases: address, data and release. The lengths of the address and data phases are set by parameters. Read data and a one-cycle done pulse are returned in both cases.

Top module: `xmem_router`

## Requirements
- R1: With mode_i=0, an indirect access (ptr_i=0) or a pointer access whose address is below 0100h reads or writes internal RAM entry addr_i[7:0]. done_o pulses in the cycle after the request. A read returns the byte last written to that entry, and every entry reads 00h after reset.
- R2: An internal access drives none of the bus pins: ale_o=0, lo_oe_o=0, hi_oe_o=0, rd_no_o=1, wr_no_o=1.
- R3: With mode_i=0, a pointer access at 0100h to FFFFh runs an external bus cycle.
- R4: With mode_i=1, every access runs an external bus cycle, and the internal RAM keeps its contents.
- R5: An indirect external access puts addr_i[7:0] on lo_o while ale_o is high. It keeps hi_oe_o low for the whole cycle.
- R6: A pointer external access holds hi_oe_o=1 with hi_o=addr_i[15:8] through the address and data phases. It puts addr_i[7:0] on lo_o while ale_o is high.
- R7: Each external cycle asserts exactly one strobe: wr_no_o low for a write, rd_no_o low for a read. The two strobes are never low together, and neither is low while ale_o is high.
- R8: ale_o is high for ADDR_CYC clocks, then the strobe is low for STROBE_CYC clocks, then done_o pulses. The request-to-done latency is ADDR_CYC+STROBE_CYC+1 clocks.
- R9: While rd_no_o is low, lo_oe_o is 0. rdata_o returns the lo_i value from the last strobe clock. While wr_no_o is low, lo_oe_o=1 and lo_o equals the write data.
- R10: done_o is a single-cycle pulse, and requests that arrive while an external cycle is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle |
| ptr_i | input | 1 | 1: 16-bit pointer address, 0: 8-bit indirect |
| addr_i | input | 16 | Access address (low byte only for indirect) |
| we_i | input | 1 | 1: write, 0: read |
| wdata_i | input | 8 | Write data |
| mode_i | input | 1 | 0: expanded RAM enabled, 1: all accesses external |
| rdata_o | output | 8 | Read data |
| done_o | output | 1 | Access complete pulse |
| lo_o | output | 8 | Low port output: address low byte / write data |
| lo_oe_o | output | 1 | Low port output enable |
| lo_i | input | 8 | Low port input: read data |
| hi_o | output | 8 | High port output: address high byte |
| hi_oe_o | output | 1 | High port output enable |
| ale_o | output | 1 | Address latch strobe |
| rd_no_o | output | 1 | Read strobe, active low |
| wr_no_o | output | 1 | Write strobe, active low |

## Verification
The bench targets the 00FFh/0100h pointer boundary in mode 0. A router that compared the address wrongly would send one of these to the wrong memory, and the data read back would then disagree with the bench's model. In mode 1, a write at a low pointer address must leave the internal entry with the same index unchanged. A design that also wrote internally would show up on the later mode-0 read-back. Indirect external accesses use a bench-chosen page on the high port. A design that drove the high port would corrupt the device-side address, and one that dropped the low address would do the same. Strobe counts per cycle, latency and write-data checks catch phase sequencing that is off by a clock or that fires the wrong strobe.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_REL  = 2'd3
  } bus_ph_e;

  typedef struct packed {
    logic        ptr;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } xreq_t;
endpackage

// File: rtl/xmem_route.sv
module xmem_route #(
  parameter int AW = 16,
  parameter int IW = 8
) (
  input  logic          mode_i,
  input  logic          ptr_i,
  input  logic [AW-1:0] addr_i,
  output logic          int_sel_o
);
  localparam int HW = AW - IW;
  logic hi_zero;
  assign hi_zero   = (addr_i[AW-1:IW] == HW'(0));
  // mode 1 forces external; mode 0 keeps indirect and low pointer on chip
  assign int_sel_o = !mode_i && (!ptr_i || hi_zero);
endmodule

// File: rtl/xmem_ram.sv
module xmem_ram #(
  parameter int IW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << IW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/xmem_bus.sv
module xmem_bus
  import xmem_pkg::*;
#(
  parameter int ADDR_CYC   = 1,
  parameter int STROBE_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  xreq_t       req_i,
  output logic        idle_o,
  output logic        smp_o,
  output logic        done_o,
  output logic [7:0]  lo_o,
  output logic        lo_oe_o,
  output logic [7:0]  hi_o,
  output logic        hi_oe_o,
  output logic        ale_o,
  output logic        rd_no_o,
  output logic        wr_no_o
);
  localparam int CMAX = (ADDR_CYC > STROBE_CYC) ? ADDR_CYC : STROBE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
  localparam logic [CW-1:0] S_LAST = CW'(STROBE_CYC - 1);

  bus_ph_e       ph_q;
  logic [CW-1:0] cnt_q;
  xreq_t         req_q;
  logic          in_addr, in_data, data_last;

  assign in_addr   = (ph_q == PH_ADDR);
  assign in_data   = (ph_q == PH_DATA);
  assign data_last = in_data && (cnt_q == S_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      req_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_ADDR;
          cnt_q <= '0;
          req_q <= req_i;
        end
        PH_ADDR: begin
          if (cnt_q == A_LAST) begin
            ph_q  <= PH_DATA;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt_q == S_LAST) begin
            ph_q  <= PH_REL;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_REL:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o  = (ph_q == PH_IDLE);
  assign done_o  = (ph_q == PH_REL);
  assign smp_o   = data_last && !req_q.we;
  assign ale_o   = in_addr;
  assign lo_oe_o = in_addr || (in_data && req_q.we);
  assign lo_o    = in_addr ? req_q.addr[7:0] : (lo_oe_o ? req_q.wdata : 8'h00);
  // high port stays free on indirect cycles for external paging
  assign hi_oe_o = req_q.ptr && (in_addr || in_data);
  assign hi_o    = hi_oe_o ? req_q.addr[15:8] : 8'h00;
  assign rd_no_o = !(in_data && !req_q.we);
  assign wr_no_o = !(in_data && req_q.we);
endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmem_pkg::*;
#(
  parameter int ADDR_CYC   = 1,
  parameter int STROBE_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        ptr_i,
  input  logic [15:0] addr_i,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  input  logic        mode_i,
  output logic [7:0]  rdata_o,
  output logic        done_o,
  output logic [7:0]  lo_o,
  output logic        lo_oe_o,
  input  logic [7:0]  lo_i,
  output logic [7:0]  hi_o,
  output logic        hi_oe_o,
  output logic        ale_o,
  output logic        rd_no_o,
  output logic        wr_no_o
);
  localparam int AW = 16;
  localparam int IW = 8;
  localparam int DW = 8;

  logic          int_sel, bus_idle, bus_smp, bus_done;
  logic          accept, int_go, ext_go;
  logic [DW-1:0] ram_rdata, rdata_q;
  logic          int_done_q;
  xreq_t         req;

  assign req    = '{ptr: ptr_i, we: we_i, addr: addr_i, wdata: wdata_i};
  assign accept = req_i && bus_idle;
  assign int_go = accept && int_sel;
  assign ext_go = accept && !int_sel;

  xmem_route #(.AW(AW), .IW(IW)) i_route (
    .mode_i    (mode_i),
    .ptr_i     (ptr_i),
    .addr_i    (addr_i),
    .int_sel_o (int_sel)
  );

  xmem_ram #(.IW(IW), .DW(DW)) i_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (int_go && we_i),
    .idx_i   (addr_i[IW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  xmem_bus #(.ADDR_CYC(ADDR_CYC), .STROBE_CYC(STROBE_CYC)) i_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ext_go),
    .req_i   (req),
    .idle_o  (bus_idle),
    .smp_o   (bus_smp),
    .done_o  (bus_done),
    .lo_o    (lo_o),
    .lo_oe_o (lo_oe_o),
    .hi_o    (hi_o),
    .hi_oe_o (hi_oe_o),
    .ale_o   (ale_o),
    .rd_no_o (rd_no_o),
    .wr_no_o (wr_no_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      int_done_q <= 1'b0;
    end else begin
      int_done_q <= int_go;
      if (int_go && !we_i) rdata_q <= ram_rdata;
      else if (bus_smp)    rdata_q <= lo_i;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = int_done_q || bus_done;
endmodule

// File: rtl/xmem_router_chk.sv
module xmem_router_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic ale_o,
  input logic rd_no_o,
  input logic wr_no_o,
  input logic lo_oe_o,
  input logic hi_oe_o,
  input logic int_go
);
  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no_o && !wr_no_o));
  a_r7_ale_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no_o && wr_no_o));
  a_r8_strobe_after_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (!rd_no_o || !wr_no_o));
  a_r9_read_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no_o |-> !lo_oe_o);
  a_r9_write_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no_o |-> lo_oe_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_int_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_go |-> (!ale_o && rd_no_o && wr_no_o && !lo_oe_o && !hi_oe_o));
  a_r2_int_quiet_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_go |=> (!ale_o && rd_no_o && wr_no_o && !lo_oe_o && !hi_oe_o));
endmodule

bind xmem_router xmem_router_chk i_chk (.*);

// File: tb/test_xmem_router.sv
`timescale 1ns/1ps
module test_xmem_router;
  localparam int A_CYC = 1;
  localparam int S_CYC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, ptr = 0, we = 0, mode = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, lo_in = '0;
  logic [7:0] rdata, lo_out, hi_out;
  logic done, lo_oe, hi_oe, ale, rd_n, wr_n;

  always #2 clk = ~clk;

  xmem_router #(.ADDR_CYC(A_CYC), .STROBE_CYC(S_CYC)) i_xmem_router (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ptr_i(ptr), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .mode_i(mode), .rdata_o(rdata), .done_o(done),
    .lo_o(lo_out), .lo_oe_o(lo_oe), .lo_i(lo_in), .hi_o(hi_out), .hi_oe_o(hi_oe),
    .ale_o(ale), .rd_no_o(rd_n), .wr_no_o(wr_n)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_int [256];
  logic [7:0] exp_ext [int];
  logic [7:0] dev_mem [int];
  logic [15:0] dev_addr = '0;
  logic [7:0] page = '0;

  // per-access pin monitor
  int n_ale, n_rd, n_wr, n_act, n_hi_oe;
  logic bad_lo_addr, bad_hi, bad_wdat;
  logic [15:0] m_addr;
  logic m_ptr;
  logic [7:0] m_wd;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ext_rd(input int a);
    return exp_ext.exists(a) ? exp_ext[a] : 8'hFF;
  endfunction

  // external memory device
  always @(negedge clk) begin
    if (ale) dev_addr = hi_oe ? {hi_out, lo_out} : {page, lo_out};
    if (!rd_n) lo_in = dev_mem.exists(int'(dev_addr)) ? dev_mem[int'(dev_addr)] : 8'hFF;
    if (!wr_n && lo_oe) dev_mem[int'(dev_addr)] = lo_out;
    if (ale) begin
      n_ale++;
      if (lo_out != m_addr[7:0] || !lo_oe) bad_lo_addr = 1;
    end
    if (!rd_n) n_rd++;
    if (!wr_n) begin
      n_wr++;
      if (!lo_oe || lo_out != m_wd) bad_wdat = 1;
    end
    if (ale || !rd_n || !wr_n || lo_oe || hi_oe) n_act++;
    if (hi_oe) begin
      n_hi_oe++;
      if (hi_out != m_addr[15:8]) bad_hi = 1;
    end
  end

  task automatic access(input logic md, input logic p, input logic [15:0] a,
                        input logic w, input logic [7:0] d, input string tag);
    logic ext;
    int ea, lat;
    logic [7:0] expv;
    ext = md || (p && a[15:8] != 8'h00);
    ea  = p ? int'(a) : int'({page, a[7:0]});
    expv = ext ? ext_rd(ea) : exp_int[a[7:0]];
    n_ale = 0; n_rd = 0; n_wr = 0; n_act = 0; n_hi_oe = 0;
    bad_lo_addr = 0; bad_hi = 0; bad_wdat = 0;
    m_addr = a; m_ptr = p; m_wd = d;
    mode = md; ptr = p; addr = a; we = w; wdata = d; req = 1;
    @(negedge clk);
    req = 0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    if (ext) begin
      chk(lat == A_CYC + S_CYC + 1, {tag, " R8 latency"}, lat, A_CYC + S_CYC + 1);
      chk(n_ale == A_CYC, {tag, " R8 ale clocks"}, n_ale, A_CYC);
      chk(w ? (n_wr == S_CYC && n_rd == 0) : (n_rd == S_CYC && n_wr == 0),
          {tag, " R7 strobe"}, w ? n_wr : n_rd, S_CYC);
      chk(!bad_lo_addr, {tag, " R5/R6 low address"}, bad_lo_addr, 0);
      if (p) chk(n_hi_oe == A_CYC + S_CYC && !bad_hi, {tag, " R6 high port"}, n_hi_oe, A_CYC + S_CYC);
      else   chk(n_hi_oe == 0, {tag, " R5 high port free"}, n_hi_oe, 0);
      if (w) begin
        chk(!bad_wdat, {tag, " R9 write data"}, bad_wdat, 0);
        exp_ext[ea] = d;
      end else begin
        chk(rdata == expv, {tag, " R3/R4/R9 read data"}, rdata, expv);
      end
    end else begin
      chk(lat == 1, {tag, " R1 latency"}, lat, 1);
      chk(n_act == 0, {tag, " R2 pins quiet"}, n_act, 0);
      if (w) exp_int[a[7:0]] = d;
      else chk(rdata == expv, {tag, " R1 read data"}, rdata, expv);
    end
    @(negedge clk);
    chk(!done, {tag, " R10 done pulse"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) exp_int[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && rd_n && wr_n && !ale && !lo_oe && !hi_oe, "reset R2 pins idle", done, 0);
    access(0, 1, 16'h0077, 0, 8'h00, "reset R1 ram clear");
    // R1 internal write/read across address forms
    access(0, 0, 16'h003C, 1, 8'hA5, "R1 wr indirect");
    access(0, 1, 16'h003C, 0, 8'h00, "R1 rd ptr low");
    // R3 boundary
    access(0, 1, 16'h00FF, 1, 8'h11, "R1 ptr 00FF");
    access(0, 1, 16'h0100, 1, 8'h22, "R3 ptr 0100");
    access(0, 1, 16'h0100, 0, 8'h00, "R3 rd 0100");
    access(0, 1, 16'h00FF, 0, 8'h00, "R1 rd 00FF");
    // R4 mode 1 leaves internal RAM alone
    access(1, 1, 16'h003C, 1, 8'h5A, "R4 wr ext low ptr");
    access(0, 0, 16'h003C, 0, 8'h00, "R4 internal kept");
    access(1, 1, 16'h003C, 0, 8'h00, "R4 rd ext low ptr");
    // R5 indirect with page bits
    page = 8'h7E;
    access(1, 0, 16'h0042, 1, 8'hC3, "R5 wr paged");
    access(1, 1, 16'h7E42, 0, 8'h00, "R5 rd via ptr");
    // R10 request during busy ignored
    mode = 1; ptr = 1; addr = 16'h2000; we = 1; wdata = 8'h99; req = 1;
    @(negedge clk);
    addr = 16'h3000; wdata = 8'h66;
    @(negedge clk);
    req = 0;
    repeat (A_CYC + S_CYC + 2) @(negedge clk);
    exp_ext[16'h2000] = 8'h99;
    access(1, 1, 16'h3000, 0, 8'h00, "R10 busy req ignored");
    access(1, 1, 16'h2000, 0, 8'h00, "R10 first req kept");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ra;
      ra = 16'($urandom);
      if ($urandom_range(0, 2) == 0) ra[15:8] = 8'h00;
      if ($urandom_range(0, 3) == 0) ra[15:4] = 12'h010;
      page = 8'($urandom_range(0, 3));
      access(1'($urandom), 1'($urandom), ra, 1'($urandom), 8'($urandom), "rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule